// File: doc/BRIEF.md
# Programmable-Duty Common Scan Sequencer

This block produces the row-scan timing for a character LCD with seventeen common lines. Three mode inputs choose its behaviour: one line or two lines of text, whether an extra row for a 100-dot symbol line is used, and which way the scan runs. Together the first two inputs fix the duty at 1/8, 1/9, 1/16 or 1/17. Each pulse on a row-period tick moves a single selected common to the next active row. When the scan wraps back to the first row, the block raises a one-cycle frame-start pulse and inverts a frame polarity bit, which the analog drive uses for AC drive.

Commons above the active duty are never selected. The mode inputs are captured only when the scan wraps, so every frame is scanned entirely under one mode. Analog levels, bias and clock generation are handled elsewhere. This block supplies only the digital select pattern.

Top module: `com_scan_seq`

## Requirements
- R1: After reset, only `com_sel` bit 0 is high, `frame_start` is 0 and `frame_pol` is 0. The active mode is one line, no symbol row, forward scan.
- R2: The duty is set by the active mode. `two_line`=0 with `sym_row`=0 gives 8 rows, `two_line`=0 with `sym_row`=1 gives 9, `two_line`=1 with `sym_row`=0 gives 16, and `two_line`=1 with `sym_row`=1 gives 17.
- R3: Exactly one bit of `com_sel` is high in every cycle. No bit at an index equal to or above the duty is ever high, so at 1/8 duty bits 8 to 16 stay low, at 1/9 bits 9 to 16, and at 1/16 bit 16.
- R4: The row position changes only on a clock edge where `row_tick` is high. It holds in all other cycles.
- R5: With `reverse`=0, scan position k (0 for the first row of a frame) selects `com_sel` bit k. With `reverse`=1, it selects bit duty-1-k.
- R6: A tick at the last row returns the scan to position 0. `frame_start` is high for exactly the one cycle that follows that edge, and it is low at all other times.
- R7: `frame_pol` inverts on each wrap and holds otherwise.
- R8: `two_line`, `sym_row` and `reverse` are sampled only on a wrapping tick. Changes between wraps have no effect on `com_sel` until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_tick | input | 1 | One-cycle pulse per row period |
| two_line | input | 1 | 1 selects two text lines |
| sym_row | input | 1 | 1 adds the symbol-line row |
| reverse | input | 1 | 1 runs the scan from the top active row downward |
| com_sel | output | 17 | One-hot common select, bit 0 is the first common |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |
| frame_pol | output | 1 | Frame polarity for AC drive |

## Verification
Two events can land on the same clock edge: the tick that wraps the scan, and a change of mode that must apply from that frame onward. The bench changes the mode inputs at the same time as the wrapping tick, and also at points in the middle of a frame. A reference model in the bench predicts `com_sel`, `frame_start` and `frame_pol` after every tick and during the idle cycles between ticks. It expects the new duty and direction to take effect at once on the wrap, and not before it.

// File: rtl/com_scan_pkg.sv
package com_scan_pkg;

  typedef struct packed {
    logic two_line;
    logic sym_row;
    logic rev;
  } scan_mode_t;

  // Row count per frame for a given mode (R2)
  function automatic int unsigned duty_of(scan_mode_t m, int unsigned line_rows);
    int unsigned d;
    d = m.two_line ? 2 * line_rows : line_rows;
    if (m.sym_row) d = d + 1;
    return d;
  endfunction

endpackage

// File: rtl/com_frame_ctl.sv
module com_frame_ctl
  import com_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrap,
  input  scan_mode_t mode_in,
  output scan_mode_t mode_act,
  output logic       frame_start,
  output logic       frame_pol
);

  scan_mode_t mode_nxt;
  logic       start_nxt;
  logic       pol_nxt;

  always_comb begin
    mode_nxt  = mode_act;
    start_nxt = 1'b0;
    pol_nxt   = frame_pol;
    if (wrap) begin
      mode_nxt  = mode_in;
      start_nxt = 1'b1;
      pol_nxt   = ~frame_pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_act    <= '0;
      frame_start <= 1'b0;
      frame_pol   <= 1'b0;
    end else begin
      mode_act    <= mode_nxt;
      frame_start <= start_nxt;
      frame_pol   <= pol_nxt;
    end
  end

  // R8: the active mode moves only on the edge that also raises frame_start
  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> $stable(mode_act));

  // R7: polarity inverts on each frame start and is otherwise steady
  assert_pol_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (frame_pol != $past(frame_pol)));
  assert_pol_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> $stable(frame_pol));

  // R6: frame start never lasts two cycles (the duty is at least 8 rows)
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

endmodule

// File: rtl/com_row_ctr.sv
module com_row_ctr #(
  parameter int unsigned ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_tick,
  input  logic [ROW_W-1:0] duty,
  output logic [ROW_W-1:0] row_idx,
  output logic             wrap
);

  logic             at_last;
  logic [ROW_W-1:0] row_nxt;

  always_comb begin
    at_last = (row_idx == duty - ROW_W'(1));
    wrap    = row_tick && at_last;
    row_nxt = row_idx;
    if (row_tick) begin
      row_nxt = at_last ? '0 : row_idx + ROW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_idx <= '0;
    else        row_idx <= row_nxt;
  end

  // R4: position holds without a tick
  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !row_tick |=> $stable(row_idx));

  // R3: position stays inside the active rows
  assert_row_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    row_idx < duty);

endmodule

// File: rtl/com_sel_dec.sv
module com_sel_dec #(
  parameter int unsigned NUM_COM = 17,
  parameter int unsigned ROW_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ROW_W-1:0]   row_idx,
  input  logic [ROW_W-1:0]   duty,
  input  logic               rev,
  output logic [NUM_COM-1:0] com_sel
);

  logic [ROW_W-1:0] target;

  always_comb begin
    target = rev ? (duty - ROW_W'(1) - row_idx) : row_idx;
  end

  for (genvar i = 0; i < NUM_COM; i++) begin : g_com
    always_comb begin
      com_sel[i] = (ROW_W'(i) < duty) && (ROW_W'(i) == target);
    end
  end

  // R3: exactly one common is selected
  assert_one_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_sel) == 1);

  // R3: nothing at or above the duty is selected
  assert_unused_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (com_sel >> duty) == '0);

endmodule

// File: rtl/com_scan_seq.sv
module com_scan_seq
  import com_scan_pkg::*;
#(
  parameter int unsigned LINE_ROWS = 8,
  localparam int unsigned NUM_COM  = 2 * LINE_ROWS + 1,
  localparam int unsigned ROW_W    = $clog2(NUM_COM + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               row_tick,
  input  logic               two_line,
  input  logic               sym_row,
  input  logic               reverse,
  output logic [NUM_COM-1:0] com_sel,
  output logic               frame_start,
  output logic               frame_pol
);

  scan_mode_t       mode_in;
  scan_mode_t       mode_act;
  logic [ROW_W-1:0] duty;
  logic [ROW_W-1:0] row_idx;
  logic             wrap;

  always_comb begin
    mode_in.two_line = two_line;
    mode_in.sym_row  = sym_row;
    mode_in.rev      = reverse;
    duty             = ROW_W'(duty_of(mode_act, LINE_ROWS));
  end

  com_frame_ctl u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrap        (wrap),
    .mode_in     (mode_in),
    .mode_act    (mode_act),
    .frame_start (frame_start),
    .frame_pol   (frame_pol)
  );

  com_row_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_tick (row_tick),
    .duty     (duty),
    .row_idx  (row_idx),
    .wrap     (wrap)
  );

  com_sel_dec #(.NUM_COM(NUM_COM), .ROW_W(ROW_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_idx (row_idx),
    .duty    (duty),
    .rev     (mode_act.rev),
    .com_sel (com_sel)
  );

  // R6: a frame opens on the first row of the scan
  assert_start_at_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (row_idx == '0));

endmodule

// File: tb/com_scan_seq_test.sv
module com_scan_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 17;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         row_tick;
  logic         two_line, sym_row, reverse;
  logic [N-1:0] com_sel;
  logic         frame_start, frame_pol;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [N-1:0] sel;
    logic         fs;
    logic         pol;
    string        tag;
  } exp_t;

  exp_t  sb[$];
  string cur_tag = "R5";

  // reference model state
  int   m_row = 0;
  logic m_two = 0, m_sym = 0, m_rev = 0, m_pol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  com_scan_seq uut (
    .clk(clk), .rst_n(rst_n), .row_tick(row_tick),
    .two_line(two_line), .sym_row(sym_row), .reverse(reverse),
    .com_sel(com_sel), .frame_start(frame_start), .frame_pol(frame_pol)
  );

  function automatic int m_duty();
    return (m_two ? 16 : 8) + (m_sym ? 1 : 0);
  endfunction

  function automatic logic [N-1:0] m_sel();
    int idx;
    idx = m_rev ? (m_duty() - 1 - m_row) : m_row;
    return N'(1) << idx;
  endfunction

  task automatic push(logic fs, string tag);
    exp_t e;
    e.sel = m_sel();
    e.fs  = fs;
    e.pol = m_pol;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // driver: one tick, then idle cycles, each result pushed to the scoreboard
  task automatic tick(int idle);
    logic fs;
    @(negedge clk);
    row_tick = 1'b1;
    @(posedge clk);
    #1;
    row_tick = 1'b0;
    fs = 1'b0;
    if (m_row == m_duty() - 1) begin
      m_row = 0;
      m_two = two_line; m_sym = sym_row; m_rev = reverse;
      m_pol = ~m_pol;
      fs    = 1'b1;
    end else begin
      m_row = m_row + 1;
    end
    push(fs, fs ? "R6" : cur_tag);
    for (int k = 0; k < idle; k++) begin
      @(posedge clk);
      #1;
      push(1'b0, "R4");
    end
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (com_sel !== e.sel) begin
        bad++;
        $display("FAIL %s com_sel act=%h exp=%h", e.tag, com_sel, e.sel);
      end
      total++;
      if (frame_start !== e.fs) begin
        bad++;
        $display("FAIL R6 frame_start act=%b exp=%b (%s)", frame_start, e.fs, e.tag);
      end
      total++;
      if (frame_pol !== e.pol) begin
        bad++;
        $display("FAIL R7 frame_pol act=%b exp=%b", frame_pol, e.pol);
      end
      total++;
      if ($countones(com_sel) != 1) begin
        bad++;
        $display("FAIL R3 select count act=%0d exp=1", $countones(com_sel));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; row_tick = 1'b0;
    two_line = 1'b0; sym_row = 1'b0; reverse = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (com_sel !== N'(1) || frame_start !== 1'b0 || frame_pol !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset act=%h/%b/%b exp=%h/0/0", com_sel, frame_start, frame_pol, N'(1));
    end
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R2 / R5: 1/8 duty forward, two full frames with holds between ticks
    cur_tag = "R2";
    for (int i = 0; i < 16; i++) tick(i % 3);

    // R8: mode change in mid-frame is deferred
    cur_tag = "R8";
    tick(1); tick(1);
    @(negedge clk); sym_row = 1'b1; reverse = 1'b1;
    for (int i = 0; i < 6; i++) tick(0);
    // 1/9 reverse now active
    cur_tag = "R5";
    for (int i = 0; i < 18; i++) tick(1);

    // R2: two lines, forward (changed mid-frame, applied at the wrap)
    @(negedge clk); two_line = 1'b1; sym_row = 1'b0; reverse = 1'b0;
    cur_tag = "R2";
    for (int i = 0; i < 9 + 32; i++) tick(0);

    // collision: mode change set up at the wrapping tick itself (R8 with R6)
    cur_tag = "R8";
    while (m_row != 15) tick(0);
    @(negedge clk); sym_row = 1'b1; reverse = 1'b1;
    tick(2);
    cur_tag = "R3";
    for (int i = 0; i < 34; i++) tick(1);

    // back to 1/8 via a collision, reverse
    while (m_row != 16) tick(0);
    @(negedge clk); two_line = 1'b0; sym_row = 1'b0;
    cur_tag = "R8";
    tick(1);
    cur_tag = "R5";
    for (int i = 0; i < 10; i++) tick(1);

    wait (sb.size() == 0);
    @(negedge clk);
    #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule